// File: doc/BRIEF.md
# Write Completion Status Responder

This block sits in the read path of a 32-bit non-volatile memory built from four byte lanes. Each lane has its own active-low chip select and write enable, and all lanes share one active-low output enable. While the external programming timer reports that an internal programming cycle is running, a read does not return stored data. It returns a status word built from the last value written on the bus. In every lane the top bit is inverted, so a host that polls sees the complement of what it wrote. Bit 6 of every lane holds a flip-flop that changes state at the start of each read. A host can therefore detect the end of programming either by waiting for the top bit to come back true or by waiting for bit 6 to stop changing. When the busy input falls, reads again return the word supplied by the memory array.

The controller has three states. ST_READY is the normal read path. ST_LOAD means a write strobe is active on at least one lane and the lane bytes are being latched. ST_PROG means programming is running and status words are returned. The transitions are as follows. ST_READY goes to ST_LOAD when any lane write becomes active. ST_LOAD goes back to ST_READY when all write strobes are gone and busy is low. ST_LOAD goes to ST_PROG when all write strobes are gone and busy is high. ST_READY goes to ST_PROG when busy is high and no write is active. ST_PROG goes to ST_READY when busy is low. A write attempt that the protection logic rejects never raises busy, so no status is ever shown for it.

Top module: `wr_status_resp`

## Requirements
- R1: Reset puts the controller in ST_READY. No lane is driven, and rdata reads zero while every strobe is inactive.
- R2: Lane i is driven (lane_drv[i]=1) only when cs_n[i]=0, oe_n=0 and we_n[i]=1. The byte of rdata for an undriven lane reads zero.
- R3: Outside programming, a driven lane i returns mem_rdata[8i+7:8i] unchanged.
- R4: While lane i has cs_n[i]=0, we_n[i]=0 and oe_n=1, outside programming, its wdata byte is latched. The value on the last cycle of the strobe is the one kept.
- R5: During programming, a driven lane returns its latched byte with bit 7 inverted. The affected positions are bits 7, 15, 23 and 31.
- R6: During programming, bit 6 of every lane (bits 6, 14, 22, 30) holds the same flip-flop value. That value inverts once at each cycle in which some lane's read becomes active after no lane was reading. Its starting value is not defined.
- R7: The flip in R6 happens whether the new read is started by output enable falling, by chip select falling, or by both.
- R8: The cycle after busy is seen low in ST_PROG, the state is ST_READY. From then on the flip-flop holds, and reads return the full memory word.
- R9: Write strobes during programming leave the latched bytes unchanged.
- R10: A completed write whose busy never rises leaves the read path returning memory data.
- R11: When the write strobes end in ST_LOAD while busy is high, the next state is ST_PROG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 4 | Per-lane chip select, active low |
| we_n | input | 4 | Per-lane write enable, active low |
| oe_n | input | 1 | Shared output enable, active low |
| prog_busy | input | 1 | High while the programming timer runs |
| wdata | input | 32 | Bus write data |
| mem_rdata | input | 32 | Stored word from the memory array |
| rdata | output | 32 | Read data toward the bus |
| lane_drv | output | 4 | Per-lane bus drive enable |

## Verification
The assertions assume that the bus strobes and busy are stable across each clock edge. They also assume that busy rises only after a write has ended. The stimulus meets both assumptions by changing every input on the falling clock edge and by raising busy no earlier than the cycle in which the write strobes are released. Because the starting value of the toggle is undefined, the stimulus compares consecutive reads with each other rather than with a fixed value, and it masks bit 6 in the table of vectors.

// File: rtl/wr_status_pkg.sv
package wr_status_pkg;
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_LOAD  = 2'd1,
        ST_PROG  = 2'd2
    } wst_e;
endpackage

// File: rtl/wr_status_ctrl.sv
module wr_status_ctrl
    import wr_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_any,
    input  logic rd_any,
    input  logic prog_busy,
    output wst_e state,
    output logic in_prog,
    output logic tog
);
    wst_e st_q, st_d;
    logic rd_q;
    logic tog_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_READY;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_READY: begin
                if (wr_any)         st_d = ST_LOAD;
                else if (prog_busy) st_d = ST_PROG;
            end
            ST_LOAD: begin
                if (!wr_any) st_d = prog_busy ? ST_PROG : ST_READY;
            end
            ST_PROG: begin
                if (!prog_busy) st_d = ST_READY;
            end
            default: st_d = ST_READY;
        endcase
    end

    // read-start detector and status flip-flop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= 1'b0;
            tog_q <= 1'b0;
        end else begin
            rd_q <= rd_any;
            if (st_q == ST_PROG && rd_any && !rd_q) tog_q <= ~tog_q;
        end
    end

    // outputs
    always_comb begin
        state   = st_q;
        in_prog = (st_q == ST_PROG);
        tog     = tog_q;
    end

    // R8
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PROG && !prog_busy) |=> (st_q == ST_READY));
    // R6
    tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PROG && rd_any && !rd_q) |=> (tog_q != $past(tog_q)));
    // R8
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_PROG) |=> $stable(tog_q));
    // R11
    load_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOAD && !wr_any && prog_busy) |=> (st_q == ST_PROG));
endmodule

// File: rtl/wr_status_lane.sv
module wr_status_lane #(
    parameter int W        = 8,
    parameter int POLL_POS = 7,
    parameter int TOG_POS  = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         we_n,
    input  logic         oe_n,
    input  logic         in_prog,
    input  logic         tog,
    input  logic [W-1:0] wbyte,
    input  logic [W-1:0] mbyte,
    output logic [W-1:0] dout,
    output logic         drv,
    output logic         wr_act,
    output logic         rd_act
);
    logic [W-1:0] cap_q;
    logic [W-1:0] status;

    always_comb begin
        wr_act = !cs_n && !we_n && oe_n;
        rd_act = !cs_n && !oe_n && we_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cap_q <= '0;
        else if (wr_act && !in_prog) cap_q <= wbyte;
    end

    always_comb begin
        status           = cap_q;
        status[POLL_POS] = ~cap_q[POLL_POS];
        status[TOG_POS]  = tog;
        drv  = rd_act;
        dout = rd_act ? (in_prog ? status : mbyte) : '0;
    end

    // R9
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_prog |=> $stable(cap_q));
    // R2
    quiet_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!drv && dout == '0));
endmodule

// File: rtl/wr_status_resp.sv
module wr_status_resp
    import wr_status_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        cs_n,
    input  logic [LANES-1:0]        we_n,
    input  logic                    oe_n,
    input  logic                    prog_busy,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES*LANE_W-1:0] mem_rdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [LANES-1:0]        lane_drv
);
    localparam int POLL_POS = LANE_W - 1;
    localparam int TOG_POS  = LANE_W - 2;

    logic [LANES-1:0] wr_v, rd_v;
    logic             in_prog, tog;
    wst_e             state;

    wr_status_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_any    (|wr_v),
        .rd_any    (|rd_v),
        .prog_busy (prog_busy),
        .state     (state),
        .in_prog   (in_prog),
        .tog       (tog)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        wr_status_lane #(.W(LANE_W), .POLL_POS(POLL_POS), .TOG_POS(TOG_POS)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .cs_n    (cs_n[i]),
            .we_n    (we_n[i]),
            .oe_n    (oe_n),
            .in_prog (in_prog),
            .tog     (tog),
            .wbyte   (wdata[i*LANE_W +: LANE_W]),
            .mbyte   (mem_rdata[i*LANE_W +: LANE_W]),
            .dout    (rdata[i*LANE_W +: LANE_W]),
            .drv     (lane_drv[i]),
            .wr_act  (wr_v[i]),
            .rd_act  (rd_v[i])
        );
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (state == ST_READY));
endmodule

// File: tb/wr_status_resp_tb.sv
module wr_status_resp_tb;
    typedef struct packed {
        logic [3:0]  cs;
        logic        oe;
        logic [3:0]  we;
        logic        busy;
        logic [31:0] din;
        logic [31:0] mem;
        logic [3:0]  eoe;
        logic [31:0] eout;
        logic [31:0] mask;
        logic [7:0]  req;
    } vec_t;

    localparam logic [31:0] M1 = 32'h1234_5678;
    localparam logic [31:0] M2 = 32'hDEAD_BEEF;
    localparam logic [31:0] FM = 32'hFFFF_FFFF;
    localparam logic [31:0] SM = 32'hBFBF_BFBF;
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'hF, 1'b1, 4'hF, 1'b0, 32'h0, M1, 4'h0, 32'h0, FM, 8'd2},                  // R2 idle
        '{4'h0, 1'b0, 4'hF, 1'b0, 32'h0, M1, 4'hF, M1, FM, 8'd3},                     // R3 read
        '{4'hA, 1'b0, 4'hF, 1'b0, 32'h0, M1, 4'h5, 32'h0034_0078, FM, 8'd2},          // R2 partial lanes
        '{4'h0, 1'b1, 4'h0, 1'b0, 32'hA5C3_7E81, M1, 4'h0, 32'h0, FM, 8'd4},          // R4 write
        '{4'hF, 1'b1, 4'hF, 1'b1, 32'h0, M1, 4'h0, 32'h0, FM, 8'd11},                 // R11 end, busy
        '{4'h0, 1'b0, 4'hF, 1'b1, 32'h0, M1, 4'hF, 32'h2543_FE01, SM, 8'd5},          // R5 poll
        '{4'hF, 1'b1, 4'hF, 1'b1, 32'h0, M1, 4'h0, 32'h0, FM, 8'd2},
        '{4'h0, 1'b1, 4'h0, 1'b1, 32'hFFFF_FFFF, M1, 4'h0, 32'h0, FM, 8'd9},          // R9 write in prog
        '{4'hF, 1'b1, 4'hF, 1'b1, 32'h0, M1, 4'h0, 32'h0, FM, 8'd9},
        '{4'h0, 1'b0, 4'hF, 1'b1, 32'h0, M1, 4'hF, 32'h2543_FE01, SM, 8'd9},          // R9 unchanged
        '{4'hF, 1'b1, 4'hF, 1'b0, 32'h0, M2, 4'h0, 32'h0, FM, 8'd8},                  // R8 busy falls
        '{4'h0, 1'b0, 4'hF, 1'b0, 32'h0, M2, 4'hF, M2, FM, 8'd8},                     // R8 data again
        '{4'hD, 1'b1, 4'hD, 1'b0, 32'h0000_5500, M2, 4'h0, 32'h0, FM, 8'd10},         // R10 write
        '{4'hF, 1'b1, 4'hF, 1'b0, 32'h0, M2, 4'h0, 32'h0, FM, 8'd10},
        '{4'h0, 1'b0, 4'hF, 1'b0, 32'h0, M2, 4'hF, M2, FM, 8'd10}                     // R10 no status
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cs_n = 4'hF, we_n = 4'hF;
    logic        oe_n = 1'b1, prog_busy = 1'b0;
    logic [31:0] wdata = '0, mem_rdata = '0;
    logic [31:0] rdata;
    logic [3:0]  lane_drv;
    int n_chk = 0, n_bad = 0;
    logic b1, b2, b3;

    always #10 clk = ~clk;

    wr_status_resp u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .prog_busy(prog_busy), .wdata(wdata), .mem_rdata(mem_rdata),
        .rdata(rdata), .lane_drv(lane_drv)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] cs, input logic oe, input logic [3:0] we,
                         input logic busy, input logic [31:0] din, input logic [31:0] mem);
        @(negedge clk);
        cs_n = cs; oe_n = oe; we_n = we; prog_busy = busy; wdata = din; mem_rdata = mem;
        @(posedge clk);
        #5;
    endtask

    function automatic logic same_tog(input logic [31:0] d);
        return (d[6] == d[14]) && (d[14] == d[22]) && (d[22] == d[30]);
    endfunction

    initial begin
        #4ms;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        // R1 reset state
        check("R1", {28'h0, lane_drv}, 32'h0);
        check("R1", rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(4'h0, 1'b0, 4'hF, 1'b0, 32'h0, M2);
        check("R1", rdata, M2);   // ready state after reset returns memory

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].cs, VECS[i].oe, VECS[i].we, VECS[i].busy, VECS[i].din, VECS[i].mem);
            check($sformatf("R%0d", VECS[i].req), {28'h0, lane_drv}, {28'h0, VECS[i].eoe});
            check($sformatf("R%0d", VECS[i].req), rdata & VECS[i].mask, VECS[i].eout & VECS[i].mask);
        end

        // enter programming with a fresh write
        drive(4'h0, 1'b1, 4'h0, 1'b0, 32'h0F0F_0F0F, M1);
        drive(4'hF, 1'b1, 4'hF, 1'b1, 32'h0, M1);
        // R6 first read
        drive(4'h0, 1'b0, 4'hF, 1'b1, 32'h0, M1);
        check("R6", {31'h0, same_tog(rdata)}, 32'h1);
        check("R5", rdata & SM, 32'h8F8F_8F8F);
        b1 = rdata[6];
        // R6 restart via output enable
        drive(4'h0, 1'b1, 4'hF, 1'b1, 32'h0, M1);
        drive(4'h0, 1'b0, 4'hF, 1'b1, 32'h0, M1);
        b2 = rdata[6];
        check("R6", {31'h0, b2}, {31'h0, ~b1});
        // R6 no flip while read is held
        drive(4'h0, 1'b0, 4'hF, 1'b1, 32'h0, M1);
        check("R6", {31'h0, rdata[6]}, {31'h0, b2});
        // R7 restart via chip select only
        drive(4'hF, 1'b0, 4'hF, 1'b1, 32'h0, M1);
        drive(4'h0, 1'b0, 4'hF, 1'b1, 32'h0, M1);
        b3 = rdata[6];
        check("R7", {31'h0, b3}, {31'h0, ~b2});
        // R7 restart via both
        drive(4'hF, 1'b1, 4'hF, 1'b1, 32'h0, M1);
        drive(4'h0, 1'b0, 4'hF, 1'b1, 32'h0, M1);
        check("R7", {31'h0, rdata[6]}, {31'h0, ~b3});
        check("R7", {31'h0, same_tog(rdata)}, 32'h1);
        // R8 end of programming
        drive(4'hF, 1'b1, 4'hF, 1'b0, 32'h0, M2);
        drive(4'h0, 1'b0, 4'hF, 1'b0, 32'h0, M2);
        check("R8", rdata, M2);
        drive(4'hF, 1'b1, 4'hF, 1'b0, 32'h0, M1);
        drive(4'h0, 1'b0, 4'hF, 1'b0, 32'h0, M1);
        check("R8", rdata, M1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule